// File: doc/BRIEF.md
# Column-Bypass Array Multiplier

This block multiplies two unsigned operands combinationally. The multiplicand `x` and the multiplier `y` are each `OPW` bits wide, four by default. The result `prod` is `2*OPW` bits wide and needs no clock. The AND terms of the multiplication come from a grid of reversible-logic cells. Three-input controlled-AND cells with a zero target form every row but the last, and the last row uses cells that also return the XOR of their inputs. A carry-save array then reduces the terms row by row. Its first row is built from half adders, because no carries exist yet, and every later row uses full adders. Each cell passes its carry diagonally to the row below, and a ripple-carry row merges whatever sums and carries remain.

Every adder cell belongs to the diagonal of one multiplicand bit. A reversible 2:1 multiplexer at its output chooses between two terms. When that bit is 1 it passes the computed sum. When the bit is 0 it passes the sum arriving from the row above, so the cell's toggling never reaches the array. A zero bit makes every term in its diagonal zero, so every carry in that diagonal is zero as well. The bypass therefore keeps the result exact and needs no correction stage. The select bits are the multiplicand bits that flow through the partial-product grid.

Reversible cells expose every output. Outputs that the arithmetic does not use are gathered into an internal garbage bus.

Top module: `colskip_mult`

## Requirements
- R1: For every pair of unsigned `OPW`-bit operands, `prod` equals `x*y` as an unsigned `2*OPW`-bit value. At `OPW`=4 this covers all 256 pairs.
- R2: Bit 0 of `prod` equals `x[0] AND y[0]`.
- R3: If either operand is zero, `prod` is zero, whatever the other operand holds.
- R4: If `x` has exactly one bit set, at position i, then `prod` equals `y` shifted left by i. All other diagonals are bypassed in this case.
- R5: The bypass select of diagonal i equals `x[i]`, as carried out of the partial-product grid. When the multiplicand has zero bits between set bits (for example 4'b1010 or 4'b1001), the product is still exact.
- R6: The product never exceeds (2^OPW-1)^2. For all-ones operands at `OPW`=4 it is exactly 8'hE1, with the top bit set by the final ripple carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | OPW | Unsigned multiplicand; each bit enables its adder diagonal |
| y | input | OPW | Unsigned multiplier |
| prod | output | 2*OPW | Unsigned product x*y |

## Verification
Zero operands and lone set multiplicand bits exercise the bypass path alone. In those cases every diagonal is skipped, or all but one, so a select wired to the wrong bit shows up as a wrongly shifted or non-zero result. Multiplicands with zero bits between set bits mix computed diagonals with bypassed ones. They show whether a bypassed cell drops a sum that an active neighbour still needs. All-ones operands drive every carry chain and the final ripple to their limit. The full sweep of 256 pairs then separates any remaining wiring fault in the partial-product grid or the carry-save array.

// File: rtl/colskip_pkg.sv
package colskip_pkg;
  // operand width of the multiplier
  parameter int unsigned OPW = 4;

  // strobes from control to datapath: one enable per adder diagonal
  typedef struct packed {
    logic [OPW-1:0] diagEn;
  } ctrl_t;
endpackage

// File: rtl/colskip_gates.sv
// Reversible primitives. Every output is exposed; unused ones become garbage.

// controlled-controlled-NOT: r = a&b ^ c
module colskip_toffoli (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = b;
  assign r = (a & b) ^ c;
endmodule

// Peres cell: q = a^b, r = a&b ^ c
module colskip_peres (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
endmodule

// four-line full-adder cell: r = sum, s = carry ^ d
module colskip_hng (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  logic axb;
  assign axb = a ^ b;
  assign p = a;
  assign q = b;
  assign r = axb ^ c;
  assign s = (axb & c) ^ (a & b) ^ d;
endmodule

// reversible 2:1 mux: q = s ? b : a, r = s ? a : b
module colskip_pvmux (
  input  logic s,
  input  logic a,
  input  logic b,
  output logic p,
  output logic q,
  output logic r
);
  assign p = s;
  assign q = (~s & a) | (s & b);
  assign r = (s & a) | (~s & b);
endmodule

// File: rtl/colskip_ctrl.sv
module colskip_ctrl
  import colskip_pkg::*;
(
  input  logic [OPW-1:0] xProp,
  output ctrl_t          ctl
);
  // a diagonal computes only when its multiplicand bit is set
  always_comb begin
    ctl.diagEn = xProp;
  end
endmodule

// File: rtl/colskip_dp.sv
module colskip_dp
  import colskip_pkg::*;
#(
  localparam int unsigned N  = OPW,
  localparam int unsigned GW = (N - 1) + N + (N - 1) * N * 4 + N * 2 + 1
) (
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  input  ctrl_t          ctl,
  output logic [N-1:0]   xProp,
  output logic [2*N-1:0] prod,
  output logic [GW-1:0]  garbage
);
  logic [N:0][N-1:0]     xChain;
  logic [N-2:0][N:0]     yChain;
  logic [N-1:0][N-1:0]   pp;
  logic [N-1:0]          gPeresQ;
  logic [N-1:1][N-1:0]   sumOut;
  logic [N-1:1][N-1:0]   carryOut;
  logic [N-1:1][N-1:0][3:0] gCell;
  logic [N-1:0][1:0]     gRip;
  logic [N:0]            rc;
  logic [N-2:0]          gYEnd;

  assign xChain[0] = x;

  // partial-product grid: x flows down the rows, y flows along each row
  for (genvar j = 0; j < N; j++) begin : g_ppRow
    if (j < N - 1) begin : g_tof
      assign yChain[j][0] = y[j];
      assign gYEnd[j]     = yChain[j][N];
      for (genvar i = 0; i < N; i++) begin : g_col
        colskip_toffoli uTof (
          .a(xChain[j][i]), .b(yChain[j][i]), .c(1'b0),
          .p(xChain[j+1][i]), .q(yChain[j][i+1]), .r(pp[j][i])
        );
      end
    end else begin : g_per
      for (genvar i = 0; i < N; i++) begin : g_col
        colskip_peres uPer (
          .a(xChain[j][i]), .b(y[j]), .c(1'b0),
          .p(xChain[j+1][i]), .q(gPeresQ[i]), .r(pp[j][i])
        );
      end
    end
  end

  assign xProp = xChain[N];

  // carry-save array with per-cell bypass multiplexers
  for (genvar j = 1; j < N; j++) begin : g_sumRow
    for (genvar i = 0; i < N; i++) begin : g_cell
      logic aIn;
      logic rawSum;
      if (i < N - 1) begin : g_aSrc
        if (j == 1) begin : g_first
          assign aIn = pp[0][i+1];
        end else begin : g_later
          assign aIn = sumOut[j-1][i+1];
        end
      end else begin : g_aTop
        assign aIn = 1'b0;
      end

      if (j == 1) begin : g_half
        colskip_peres uHa (
          .a(aIn), .b(pp[j][i]), .c(1'b0),
          .p(gCell[j][i][0]), .q(rawSum), .r(carryOut[j][i])
        );
        assign gCell[j][i][1] = 1'b0;
      end else begin : g_full
        colskip_hng uFa (
          .a(aIn), .b(pp[j][i]), .c(carryOut[j-1][i]), .d(1'b0),
          .p(gCell[j][i][0]), .q(gCell[j][i][1]),
          .r(rawSum), .s(carryOut[j][i])
        );
      end

      colskip_pvmux uMux (
        .s(ctl.diagEn[i]), .a(aIn), .b(rawSum),
        .p(gCell[j][i][2]), .q(sumOut[j][i]), .r(gCell[j][i][3])
      );
    end
  end

  // low product bits leave the array directly
  assign prod[0] = pp[0][0];
  for (genvar j = 1; j < N; j++) begin : g_lowBits
    assign prod[j] = sumOut[j][0];
  end

  // final ripple-carry merge
  assign rc[0] = 1'b0;
  for (genvar k = 0; k < N; k++) begin : g_ripple
    logic ra;
    if (k < N - 1) begin : g_ra
      assign ra = sumOut[N-1][k+1];
    end else begin : g_raTop
      assign ra = 1'b0;
    end
    if (k == 0) begin : g_ha
      colskip_peres uRha (
        .a(ra), .b(carryOut[N-1][k]), .c(1'b0),
        .p(gRip[k][0]), .q(prod[N+k]), .r(rc[k+1])
      );
      assign gRip[k][1] = rc[k];
    end else begin : g_fa
      colskip_hng uRfa (
        .a(ra), .b(carryOut[N-1][k]), .c(rc[k]), .d(1'b0),
        .p(gRip[k][0]), .q(gRip[k][1]), .r(prod[N+k]), .s(rc[k+1])
      );
    end
  end

  assign garbage = {rc[N], gRip, gCell, gPeresQ, gYEnd};
endmodule

// File: rtl/colskip_mult.sv
module colskip_mult
  import colskip_pkg::*;
#(
  localparam int unsigned N = OPW
) (
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] prod
);
  ctrl_t         ctl;
  logic [N-1:0]  xProp;
  logic [(N-1) + N + (N-1)*N*4 + N*2:0] garbage;

  colskip_dp uDp (
    .x(x), .y(y), .ctl(ctl), .xProp(xProp), .prod(prod), .garbage(garbage)
  );

  colskip_ctrl uCtrl (
    .xProp(xProp), .ctl(ctl)
  );
endmodule

// File: rtl/colskip_chk.sv
module colskip_chk
  import colskip_pkg::*;
#(
  localparam int unsigned N  = OPW,
  localparam int unsigned GW = (N - 1) + N + (N - 1) * N * 4 + N * 2 + 1
) (
  input logic [N-1:0]   x,
  input logic [N-1:0]   y,
  input ctrl_t          ctl,
  input logic [N-1:0]   xProp,
  input logic [2*N-1:0] prod,
  input logic [GW-1:0]  garbage
);
  logic [2*N-1:0] wideX;
  logic [2*N-1:0] wideY;
  logic [2*N-1:0] maxProd;
  assign wideX   = {{N{1'b0}}, x};
  assign wideY   = {{N{1'b0}}, y};
  assign maxProd = {{N{1'b0}}, {N{1'b1}}} * {{N{1'b0}}, {N{1'b1}}};

  always_comb begin
    if (!$isunknown({x, y})) begin
      AST_EXACT_PRODUCT: assert (prod == wideX * wideY) else $error("product mismatch"); // R1
      AST_LSB_TERM: assert (prod[0] == (x[0] & y[0])) else $error("lsb mismatch"); // R2
      AST_ZERO_OPERAND: assert (!(x == '0 || y == '0) || prod == '0) else $error("zero operand"); // R3
      AST_SINGLE_DIAG: assert ($countones(x) != 1 || $countones(prod) == $countones(y)) else $error("single diagonal"); // R4
      AST_SELECT_FOLLOWS: assert (ctl.diagEn == xProp && xProp == x) else $error("select path"); // R5
      AST_PRODUCT_CEILING: assert (prod <= maxProd) else $error("product ceiling"); // R6
      AST_GARBAGE_KNOWN: assert (!$isunknown(garbage)) else $error("garbage unknown"); // R1
    end
  end
endmodule

bind colskip_dp colskip_chk uChk (
  .x(x), .y(y), .ctl(ctl), .xProp(xProp), .prod(prod), .garbage(garbage)
);

// File: tb/colskip_mult_test.sv
module colskip_mult_test;
  localparam int unsigned N = 4;
  localparam int unsigned WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic [N-1:0]   x = '0;
  logic [N-1:0]   y = '0;
  logic [2*N-1:0] prod;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  colskip_mult uut (.x(x), .y(y), .prod(prod));

  task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: x=%0d y=%0d actual=%0d expected=%0d", req, x, y, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] xv, input logic [N-1:0] yv);
    @(negedge clk);
    x = xv;
    y = yv;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2*N-1:0] refMul(input logic [N-1:0] a, input logic [N-1:0] b);
    int unsigned r;
    r = int'(a) * int'(b);
    return r[2*N-1:0];
  endfunction

  task automatic testInitial();
    @(posedge clk);
    #1;
    check("R3 idle zero operands", prod, '0);
  endtask

  task automatic testZeroOperands();
    apply(4'd0, 4'd9);
    check("R3 zero multiplicand", prod, '0);
    apply(4'd13, 4'd0);
    check("R3 zero multiplier", prod, '0);
    apply(4'd0, 4'd15);
    check("R3 all diagonals bypassed", prod, '0);
  endtask

  task automatic testLsb();
    for (int a = 1; a < 4; a++) begin
      for (int b = 1; b < 4; b++) begin
        apply(N'(a), N'(b));
        check("R2 lsb term", {{(2*N-1){1'b0}}, prod[0]}, {{(2*N-1){1'b0}}, 1'(a & b & 1)});
      end
    end
  endtask

  task automatic testSingleDiag();
    for (int i = 0; i < N; i++) begin
      apply(N'(1 << i), 4'd11);
      check("R4 single diagonal", prod, (2*N)'(11 << i));
    end
  endtask

  task automatic testSparse();
    logic [N-1:0] pats [4] = '{4'b1010, 4'b0101, 4'b1001, 4'b0110};
    for (int k = 0; k < 4; k++) begin
      apply(pats[k], 4'd15);
      check("R5 mixed bypass", prod, refMul(pats[k], 4'd15));
      apply(pats[k], 4'd7);
      check("R5 mixed bypass", prod, refMul(pats[k], 4'd7));
    end
  endtask

  task automatic testMax();
    apply(4'd15, 4'd15);
    check("R6 all ones product", prod, 8'hE1);
    check("R6 top carry bit", {7'b0, prod[7]}, 8'd1);
  endtask

  task automatic testExhaustive();
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        apply(N'(a), N'(b));
        check("R1 exhaustive", prod, refMul(N'(a), N'(b)));
      end
    end
  endtask

  initial begin
    testInitial();
    testZeroOperands();
    testLsb();
    testSingleDiag();
    testSparse();
    testMax();
    testExhaustive();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule